// File: doc/BRIEF.md
# Calendar Alarm Match Unit

This block watches the running BCD time and date of a real-time clock and raises an alarm when that time agrees with a programmed alarm setting. There are six alarm fields: seconds, minutes, hours, date, month and day of week. Each field has its own enable bit. A field that is not enabled always counts as matching, so enabling only some fields gives periodic alarms. For example, enabling only seconds = 30 produces one alarm per minute.

The timekeeping counter outside the block presents the current time on six 7-bit inputs. It pulses `tick` for one cycle on the cycle in which those inputs first hold the new time. The block compares on that cycle only. When it finds a match, it sets a status flag and pulls the active-low interrupt low.

Interrupt behaviour depends on the mode bit:
- In latched mode, the interrupt stays low until software clears the flag.
- In pulsed mode, the interrupt is low for a fixed number of clock cycles after each match.

Software does not need to clear the flag for later alarms to fire.

Top module: `cal_alarm_match`

## Requirements
- R1: While reset is high and on the first cycle after it, `alarm_flag` is 0 and `irq_n` is 1. Reset leaves every field disabled.
- R2: A write with `wr_en` high loads `wr_data` into the field chosen by `wr_sel`. The selector codes are 0 seconds, 1 minutes, 2 hours, 3 date, 4 month and 5 day of week. In the data byte, bit 7 is the field enable and bits 6:0 are the BCD compare value, so 0xB0 means "equal to 30, enabled". Selector codes 6 and 7 change nothing. A written value takes effect from the next cycle.
- R3: A match occurs when every enabled field equals the corresponding current-time input. Disabled fields take no part in the comparison.
- R4: When all six enable bits are 0, no alarm is ever raised, whatever the time inputs do.
- R5: The comparison is made only in a cycle with `tick` high, so each tick yields at most one event. A match produces its effect on the outputs in the cycle after the tick.
- R6: On a match, `alarm_flag` becomes 1 in the next cycle.
- R7: With `pulse_mode` = 0, `irq_n` is the inverse of the flag. The interrupt stays low until `stat_clr` clears the flag. If a match and a clear fall in the same cycle, the match wins.
- R8: With `pulse_mode` = 1, `irq_n` is low for exactly PULSE_LEN cycles (default 4) after each match and then returns high. A new match during a pulse restarts the count.
- R9: A match sets the flag again each time, whether or not the flag was cleared after an earlier alarm.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick | input | 1 | One-cycle strobe: the time inputs hold a new time |
| cur_sec | input | 7 | Current seconds, BCD |
| cur_min | input | 7 | Current minutes, BCD |
| cur_hour | input | 7 | Current hours, BCD (24-hour) |
| cur_date | input | 7 | Current day of month, BCD |
| cur_month | input | 7 | Current month, BCD |
| cur_dow | input | 7 | Current day of week |
| wr_en | input | 1 | Alarm field write strobe |
| wr_sel | input | 3 | Alarm field selector |
| wr_data | input | 8 | Enable bit (7) and BCD value (6:0) |
| pulse_mode | input | 1 | 0 latched interrupt, 1 pulsed interrupt |
| stat_clr | input | 1 | Clears the alarm flag |
| alarm_flag | output | 1 | Alarm status flag |
| irq_n | output | 1 | Active-low interrupt |

## Verification
The bench sweeps whole minutes of seconds and a full week of day-of-week values against single-field alarms. It also runs a full date-and-time alarm across the 59-to-00 rollover into the alarm minute.

The following faults are targeted, each with the symptom it would cause:
- Comparing on every cycle instead of only on the tick would repeat pulses while a matching time is held without a tick.
- Treating an all-disabled setting as a match would fire on every tick.
- Letting the clear win over a simultaneous match would lose an alarm.
- A pulse length that is off by one would move the cycle in which `irq_n` rises.

Writes to the unused selector codes, and a cleared flag followed by a new match, are also checked at the outputs.

// File: rtl/alarm_pkg.sv
package alarm_pkg;

    localparam int NFIELDS = 6;
    localparam int VAL_W   = 7;
    localparam int SEL_W   = $clog2(NFIELDS + 2);

    typedef enum logic [SEL_W-1:0] {
        FLD_SEC   = 3'd0,
        FLD_MIN   = 3'd1,
        FLD_HOUR  = 3'd2,
        FLD_DATE  = 3'd3,
        FLD_MONTH = 3'd4,
        FLD_DOW   = 3'd5
    } field_e;

    typedef struct packed {
        logic             en;
        logic [VAL_W-1:0] val;
    } alm_field_t;

    function automatic alm_field_t to_field(input logic [VAL_W:0] raw);
        alm_field_t f;
        f.en  = raw[VAL_W];
        f.val = raw[VAL_W-1:0];
        return f;
    endfunction

    function automatic logic field_ok(input alm_field_t f, input logic [VAL_W-1:0] now);
        return (!f.en) || (f.val == now);
    endfunction

endpackage

// File: rtl/alarm_regs.sv
module alarm_regs
    import alarm_pkg::*;
#(
    parameter int NF = NFIELDS
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic                  wr_en,
    input  logic [SEL_W-1:0]      wr_sel,
    input  logic [VAL_W:0]        wr_data,
    output alm_field_t [NF-1:0]   fields
);

    for (genvar i = 0; i < NF; i++) begin : g_fld
        always_ff @(posedge clk) begin
            if (rst) begin
                fields[i] <= '0;
            end else if (wr_en && (wr_sel == SEL_W'(i))) begin
                fields[i] <= to_field(wr_data);
            end
        end
    end

endmodule

// File: rtl/alarm_cmp.sv
module alarm_cmp
    import alarm_pkg::*;
#(
    parameter int NF = NFIELDS
) (
    input  alm_field_t [NF-1:0]             fields,
    input  logic       [NF-1:0][VAL_W-1:0]  now,
    input  logic                            tick,
    output logic       [NF-1:0]             en_mask,
    output logic                            hit
);

    logic [NF-1:0] ok;

    for (genvar i = 0; i < NF; i++) begin : g_cmp
        assign ok[i]      = field_ok(fields[i], now[i]);
        assign en_mask[i] = fields[i].en;
    end

    assign hit = tick && (|en_mask) && (&ok);

endmodule

// File: rtl/alarm_irq.sv
module alarm_irq #(
    parameter int PULSE_LEN = 4,
    localparam int CW = $clog2(PULSE_LEN + 1)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          hit,
    input  logic          stat_clr,
    input  logic          pulse_mode,
    output logic          flag,
    output logic [CW-1:0] pcnt,
    output logic          irq_n
);

    always_ff @(posedge clk) begin
        if (rst) begin
            flag <= 1'b0;
        end else if (hit) begin
            flag <= 1'b1;
        end else if (stat_clr) begin
            flag <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pcnt <= '0;
        end else if (hit) begin
            pcnt <= CW'(PULSE_LEN);
        end else if (pcnt != '0) begin
            pcnt <= pcnt - 1'b1;
        end
    end

    always_comb begin
        if (pulse_mode) begin
            irq_n = (pcnt == '0);
        end else begin
            irq_n = !flag;
        end
    end

endmodule

// File: rtl/cal_alarm_match.sv
module cal_alarm_match
    import alarm_pkg::*;
#(
    parameter int PULSE_LEN = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic [6:0]       cur_sec,
    input  logic [6:0]       cur_min,
    input  logic [6:0]       cur_hour,
    input  logic [6:0]       cur_date,
    input  logic [6:0]       cur_month,
    input  logic [6:0]       cur_dow,
    input  logic             wr_en,
    input  logic [2:0]       wr_sel,
    input  logic [7:0]       wr_data,
    input  logic             pulse_mode,
    input  logic             stat_clr,
    output logic             alarm_flag,
    output logic             irq_n
);

    localparam int CW = $clog2(PULSE_LEN + 1);

    alm_field_t [NFIELDS-1:0]            fields;
    logic       [NFIELDS-1:0][VAL_W-1:0] now;
    logic       [NFIELDS-1:0]            en_mask;
    logic                                hit;
    logic       [CW-1:0]                 pcnt;

    assign now[FLD_SEC]   = cur_sec;
    assign now[FLD_MIN]   = cur_min;
    assign now[FLD_HOUR]  = cur_hour;
    assign now[FLD_DATE]  = cur_date;
    assign now[FLD_MONTH] = cur_month;
    assign now[FLD_DOW]   = cur_dow;

    alarm_regs #(.NF(NFIELDS)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .fields  (fields)
    );

    alarm_cmp #(.NF(NFIELDS)) u_cmp (
        .fields  (fields),
        .now     (now),
        .tick    (tick),
        .en_mask (en_mask),
        .hit     (hit)
    );

    alarm_irq #(.PULSE_LEN(PULSE_LEN)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .hit        (hit),
        .stat_clr   (stat_clr),
        .pulse_mode (pulse_mode),
        .flag       (alarm_flag),
        .pcnt       (pcnt),
        .irq_n      (irq_n)
    );

endmodule

// File: rtl/cal_alarm_match_chk.sv
module cal_alarm_match_chk #(
    parameter int PULSE_LEN = 4,
    parameter int CW = 3
) (
    input logic          clk,
    input logic          rst,
    input logic          tick,
    input logic          hit,
    input logic [5:0]    en_mask,
    input logic          stat_clr,
    input logic          pulse_mode,
    input logic          alarm_flag,
    input logic          irq_n,
    input logic [CW-1:0] pcnt
);

    // R1: outputs idle in the cycle after reset
    a_r1_reset_idle: assert property (@(posedge clk)
        $fell(rst) |-> (!alarm_flag && irq_n));

    // R4: no enabled field, no event
    a_r4_none_enabled: assert property (@(posedge clk) disable iff (rst)
        (en_mask == '0) |-> !hit);

    // R5: events only on the tick cycle
    a_r5_tick_only: assert property (@(posedge clk) disable iff (rst)
        hit |-> tick);

    // R6: a match sets the flag
    a_r6_flag_set: assert property (@(posedge clk) disable iff (rst)
        hit |=> alarm_flag);

    // R7: the flag only drops after a clear without a match
    a_r7_flag_sticky: assert property (@(posedge clk) disable iff (rst)
        (alarm_flag && !stat_clr) |=> alarm_flag);

    // R8: the pulse counter never exceeds its length
    a_r8_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        pcnt <= CW'(PULSE_LEN));

    // R8: in pulsed mode a falling interrupt follows a match
    a_r8_pulse_cause: assert property (@(posedge clk) disable iff (rst)
        (pulse_mode && $past(pulse_mode) && $fell(irq_n)) |-> $past(hit));

endmodule

bind cal_alarm_match cal_alarm_match_chk #(
    .PULSE_LEN (PULSE_LEN),
    .CW        (CW)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .tick       (tick),
    .hit        (hit),
    .en_mask    (en_mask),
    .stat_clr   (stat_clr),
    .pulse_mode (pulse_mode),
    .alarm_flag (alarm_flag),
    .irq_n      (irq_n),
    .pcnt       (pcnt)
);

// File: tb/tb_cal_alarm_match.sv
module tb_cal_alarm_match;

    localparam int PL = 4;
    localparam int WD_CYC = 200000;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       tick = 1'b0;
    logic [6:0] cur [6];
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = '0;
    logic [7:0] wr_data = '0;
    logic       pulse_mode = 1'b0;
    logic       stat_clr = 1'b0;
    logic       alarm_flag;
    logic       irq_n;

    int tests = 0;
    int fails = 0;
    bit done = 0;

    // bench model state
    logic [7:0] mreg [6];
    logic       m_flag = 1'b0;
    int         m_cnt = 0;

    always #2 clk = ~clk;

    cal_alarm_match #(.PULSE_LEN(PL)) dut (
        .clk(clk), .rst(rst), .tick(tick),
        .cur_sec(cur[0]), .cur_min(cur[1]), .cur_hour(cur[2]),
        .cur_date(cur[3]), .cur_month(cur[4]), .cur_dow(cur[5]),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .pulse_mode(pulse_mode), .stat_clr(stat_clr),
        .alarm_flag(alarm_flag), .irq_n(irq_n)
    );

    function automatic logic [6:0] bcd(input int n);
        return 7'(((n / 10) << 4) | (n % 10));
    endfunction

    function automatic logic exp_match();
        logic any = 1'b0;
        logic all = 1'b1;
        for (int i = 0; i < 6; i++) begin
            if (mreg[i][7]) begin
                any = 1'b1;
                if (mreg[i][6:0] != cur[i]) all = 1'b0;
            end
        end
        return any && all;
    endfunction

    task automatic check(input string req, input logic act, input logic exp, input string what);
        tests++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s: actual %0b expected %0b at %0t", req, what, act, exp, $time);
        end
    endtask

    // one clock cycle; inputs are set at a falling edge, outputs checked at the next one
    task automatic cyc(input logic t, input logic c, input string req);
        logic h;
        tick = t;
        stat_clr = c;
        @(posedge clk);
        h = t && exp_match();
        if (h) begin
            m_flag = 1'b1;
            m_cnt = PL;
        end else begin
            if (c) m_flag = 1'b0;
            if (m_cnt > 0) m_cnt--;
        end
        if (wr_en && wr_sel < 3'd6) mreg[wr_sel] = wr_data;
        @(negedge clk);
        wr_en = 1'b0;
        tick = 1'b0;
        stat_clr = 1'b0;
        check(req, alarm_flag, m_flag, "alarm_flag");
        check(req, irq_n, pulse_mode ? (m_cnt == 0) : !m_flag, "irq_n");
    endtask

    task automatic wr(input logic [2:0] s, input logic [7:0] d);
        wr_en = 1'b1;
        wr_sel = s;
        wr_data = d;
        cyc(1'b0, 1'b0, "R2");
    endtask

    task automatic clear_all();
        for (int i = 0; i < 6; i++) wr(3'(i), 8'h00);
        cyc(1'b0, 1'b1, "R7");
    endtask

    task automatic set_time(input int s, input int mi, input int h, input int d, input int mo, input int w);
        cur[0] = bcd(s); cur[1] = bcd(mi); cur[2] = bcd(h);
        cur[3] = bcd(d); cur[4] = bcd(mo); cur[5] = bcd(w);
    endtask

    initial begin
        #(4 * WD_CYC);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 6; i++) begin
            mreg[i] = 8'h00;
            cur[i] = 7'h00;
        end
        @(negedge clk);
        @(negedge clk);
        check("R1", alarm_flag, 1'b0, "flag in reset");
        check("R1", irq_n, 1'b1, "irq_n in reset");
        rst = 1'b0;
        cyc(1'b0, 1'b0, "R1");

        // R4: nothing enabled, sweep time
        for (int s = 0; s < 60; s++) begin
            set_time(s, 30, 11, 1, 1, 3);
            cyc(1'b1, 1'b0, "R4");
        end

        // R2: unused selector codes change nothing
        wr(3'd6, 8'h80);
        wr(3'd7, 8'h81);
        for (int s = 0; s < 3; s++) begin
            set_time(s, 0, 0, 0, 0, 0);
            cyc(1'b1, 1'b0, "R2");
        end

        // R3 R8: seconds-only alarm, pulsed, two minutes of ticks
        pulse_mode = 1'b1;
        wr(3'd0, 8'hB0);
        for (int m = 0; m < 2; m++) begin
            for (int s = 0; s < 60; s++) begin
                set_time(s, m, 11, 1, 1, 3);
                cyc(1'b1, 1'b0, "R8");
                for (int g = 0; g < 5; g++) cyc(1'b0, 1'b0, "R8");
            end
        end

        // R5: matching time held without tick, then retick
        set_time(30, 5, 11, 1, 1, 3);
        cyc(1'b1, 1'b0, "R5");
        for (int g = 0; g < 10; g++) cyc(1'b0, 1'b0, "R5");
        cyc(1'b1, 1'b0, "R5");
        // R8: retrigger during a pulse
        cyc(1'b0, 1'b0, "R8");
        cyc(1'b1, 1'b0, "R8");
        for (int g = 0; g < 6; g++) cyc(1'b0, 1'b0, "R8");

        // R9: clear then match again sets the flag
        cyc(1'b0, 1'b1, "R9");
        cyc(1'b1, 1'b0, "R9");
        for (int g = 0; g < 5; g++) cyc(1'b0, 1'b0, "R9");

        // R7: full date/time alarm, latched mode
        pulse_mode = 1'b0;
        clear_all();
        wr(3'd0, 8'h80);
        wr(3'd1, 8'hB0);
        wr(3'd2, 8'h91);
        wr(3'd3, 8'h81);
        wr(3'd4, 8'h81);
        for (int s = 55; s < 60; s++) begin
            set_time(s, 29, 11, 1, 1, 4);
            cyc(1'b1, 1'b0, "R3");
        end
        set_time(0, 30, 11, 1, 1, 4);
        cyc(1'b1, 1'b0, "R6");
        for (int s = 1; s < 20; s++) begin
            set_time(s, 30, 11, 1, 1, 4);
            cyc(1'b1, 1'b0, "R7");
        end
        cyc(1'b0, 1'b1, "R7");
        cyc(1'b0, 1'b0, "R7");
        // R3: wrong month does not match
        set_time(0, 30, 11, 1, 2, 4);
        cyc(1'b1, 1'b0, "R3");
        // R7: match and clear together, match wins
        set_time(0, 30, 11, 1, 1, 4);
        cyc(1'b1, 1'b1, "R7");
        cyc(1'b0, 1'b0, "R7");
        cyc(1'b0, 1'b1, "R7");

        // R2: day-of-week only, sweep a week
        clear_all();
        wr(3'd5, 8'h83);
        for (int w = 1; w <= 7; w++) begin
            set_time(10, 10, 10, 10, 10, w);
            cyc(1'b1, 1'b0, "R2");
            cyc(1'b0, 1'b1, "R2");
        end

        done = 1;
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    end

endmodule